// File: doc/BRIEF.md
# Eight-Pin Shared-Function GPIO Port

This block runs an eight-pin bidirectional port whose pins may be handed to other on-chip functions. Software loads two eight-bit registers, the output-enable register and the output-data register, from an internal write bus. Each register has its own write strobe. For every pin the block then works out the pad controls: drive enable, drive value and pull-up request. The pads themselves are modelled only as these control lines plus a level input. The pin levels are brought back to the read bus through a two-flop synchronizer.

The lower four pins are open-drain cells with no pull-up. Two of them can be given to a serial bus or a UART receiver, and either of those functions then drives the pin low through its own request line. The upper four pins are push-pull cells with a pull-up. Each of them can be given to a PWM channel or to a per-pin special function, and PWM wins when both are enabled. While a pin is owned by another function, the GPIO register bits for that pin keep their values but have no effect on the pad. All pad controls are registered.

Top module: `mux_gpio_port`

## Requirements
- R1: After a synchronous reset both registers read as zero. Every pad enable is then 0, every drive value is 0, and the pull-up is 1 on pins 4-7 and 0 on pins 0-3.
- R2: When `wr_oe` is high at a clock edge, `wdata` is loaded into the output-enable register. When `wr_out` is high, `wdata` is loaded into the output-data register. Bit i of each register belongs to pin i, and writing one register leaves the other unchanged.
- R3: On a GPIO-owned pin 0-3 with its enable bit at 1, a data bit of 0 sets `pad_oe`=1 and `pad_out`=0, and a data bit of 1 sets `pad_oe`=0. Pins 0-3 never drive a 1.
- R4: On a GPIO-owned pin 0-3 with its enable bit at 0, `pad_oe`=0 and `pad_pu`=0. Pins 0-3 never request a pull-up.
- R5: When `ser_bus_en` or `uart_rx_en` is 1, pins 0 and 1 leave GPIO. Pin i then has `pad_oe` equal to `alt_low[i]` and `pad_out`=0.
- R6: On a GPIO-owned pin 4-7 with its enable bit at 1, `pad_oe`=1, `pad_pu`=0 and `pad_out` equals the data bit.
- R7: On a GPIO-owned pin 4-7 with its enable bit at 0, `pad_oe`=0 and `pad_pu`=1.
- R8: When `pwm_en[k]` or `func_en[k]` is 1, pin 4+k leaves GPIO and gets `pad_oe`=1 and `pad_pu`=0. Its `pad_out` is `pwm_val[k]` if `pwm_en[k]` is 1, and `func_val[k]` otherwise.
- R9: Register writes made while a function owns a pin do not change that pin's pad. When the function releases the pin, the pin follows the registers as they stand at that point.
- R10: `rd_data` equals `pad_in` as sampled two clock edges earlier.
- R11: A change of any enable input or function input shows on the pad controls after one clock edge. A register write shows after two edges: one to load the register and one to update the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdata | input | 8 | Internal write bus |
| wr_oe | input | 1 | Write strobe for the output-enable register |
| wr_out | input | 1 | Write strobe for the output-data register |
| rd_data | output | 8 | Synchronized pin levels |
| ser_bus_en | input | 1 | Serial bus takes pins 0-1 |
| uart_rx_en | input | 1 | UART receiver takes pins 0-1 |
| alt_low | input | 2 | Pull-low requests from the pin 0-1 function |
| pwm_en | input | 4 | PWM ownership of pins 4-7 |
| pwm_val | input | 4 | PWM levels for pins 4-7 |
| func_en | input | 4 | Special-function ownership of pins 4-7 |
| func_val | input | 4 | Special-function levels for pins 4-7 |
| pad_in | input | 8 | Pin levels seen at the pads |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables |
| pad_pu | output | 8 | Pad pull-up requests |

## Verification
The bench writes a data pattern with mixed ones and zeros while the enable register is set. It then checks that each open-drain pin lets go on a 1 and pulls low on a 0; a design that drove the 1 would make these pins push-pull. It turns on PWM and the special function for the same pin and checks that PWM wins; a reversed priority shows up as the wrong level. It also writes the registers while the pins are owned by other functions, then releases them. A design that passed writes straight through would move the pads early, and one that dropped those writes would come back with stale values. Cycle-exact checks of the single-edge and double-edge paths catch a missing or extra synchronizer or pad register.

// File: rtl/mux_gpio_pkg.sv
package mux_gpio_pkg;

  typedef struct packed {
    logic oe;
    logic out;
    logic pu;
  } pad_ctl_t;

  localparam pad_ctl_t OD_IDLE = '{oe: 1'b0, out: 1'b0, pu: 1'b0};
  localparam pad_ctl_t PP_IDLE = '{oe: 1'b0, out: 1'b0, pu: 1'b1};

endpackage

// File: rtl/mux_gpio_regs.sv
module mux_gpio_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] wdata,
  input  logic             wr_oe,
  input  logic             wr_out,
  output logic [WIDTH-1:0] oe_q,
  output logic [WIDTH-1:0] out_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      out_q <= '0;
    end else begin
      if (wr_oe)  oe_q  <= wdata;
      if (wr_out) out_q <= wdata;
    end
  end

endmodule

// File: rtl/mux_gpio_od_cell.sv
module mux_gpio_od_cell
  import mux_gpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     gpio_oe,
  input  logic     gpio_out,
  input  logic     alt_own,
  input  logic     alt_low,
  output pad_ctl_t ctl
);

  pad_ctl_t nxt;

  always_comb begin
    nxt = OD_IDLE;
    if (alt_own) nxt.oe = alt_low;
    else         nxt.oe = gpio_oe & ~gpio_out;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= OD_IDLE;
    else     ctl <= nxt;
  end

endmodule

// File: rtl/mux_gpio_pp_cell.sv
module mux_gpio_pp_cell
  import mux_gpio_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     gpio_oe,
  input  logic     gpio_out,
  input  logic     pwm_on,
  input  logic     pwm_lvl,
  input  logic     func_on,
  input  logic     func_lvl,
  output pad_ctl_t ctl
);

  pad_ctl_t nxt;

  always_comb begin
    if (pwm_on) begin
      nxt = '{oe: 1'b1, out: pwm_lvl, pu: 1'b0};
    end else if (func_on) begin
      nxt = '{oe: 1'b1, out: func_lvl, pu: 1'b0};
    end else begin
      nxt = '{oe: gpio_oe, out: gpio_out, pu: ~gpio_oe};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= PP_IDLE;
    else     ctl <= nxt;
  end

endmodule

// File: rtl/mux_gpio_sync.sv
module mux_gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/mux_gpio_port.sv
module mux_gpio_port
  import mux_gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned OD_PINS     = 4,
  parameter int unsigned SHARED_PINS = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PP_PINS    = NUM_PINS - OD_PINS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PINS-1:0]    wdata,
  input  logic                   wr_oe,
  input  logic                   wr_out,
  output logic [NUM_PINS-1:0]    rd_data,
  input  logic                   ser_bus_en,
  input  logic                   uart_rx_en,
  input  logic [SHARED_PINS-1:0] alt_low,
  input  logic [PP_PINS-1:0]     pwm_en,
  input  logic [PP_PINS-1:0]     pwm_val,
  input  logic [PP_PINS-1:0]     func_en,
  input  logic [PP_PINS-1:0]     func_val,
  input  logic [NUM_PINS-1:0]    pad_in,
  output logic [NUM_PINS-1:0]    pad_out,
  output logic [NUM_PINS-1:0]    pad_oe,
  output logic [NUM_PINS-1:0]    pad_pu
);

  logic [NUM_PINS-1:0] oe_q;
  logic [NUM_PINS-1:0] out_q;
  logic                shared_own;
  pad_ctl_t            ctl [NUM_PINS];

  assign shared_own = ser_bus_en | uart_rx_en;

  mux_gpio_regs #(.WIDTH(NUM_PINS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wdata  (wdata),
    .wr_oe  (wr_oe),
    .wr_out (wr_out),
    .oe_q   (oe_q),
    .out_q  (out_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    if (i < OD_PINS) begin : g_od
      logic own_i;
      logic low_i;
      if (i < SHARED_PINS) begin : g_shared
        assign own_i = shared_own;
        assign low_i = alt_low[i];
      end else begin : g_plain
        assign own_i = 1'b0;
        assign low_i = 1'b0;
      end
      mux_gpio_od_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .gpio_oe  (oe_q[i]),
        .gpio_out (out_q[i]),
        .alt_own  (own_i),
        .alt_low  (low_i),
        .ctl      (ctl[i])
      );
    end else begin : g_pp
      mux_gpio_pp_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .gpio_oe  (oe_q[i]),
        .gpio_out (out_q[i]),
        .pwm_on   (pwm_en[i-OD_PINS]),
        .pwm_lvl  (pwm_val[i-OD_PINS]),
        .func_on  (func_en[i-OD_PINS]),
        .func_lvl (func_val[i-OD_PINS]),
        .ctl      (ctl[i])
      );
    end
    assign pad_oe[i]  = ctl[i].oe;
    assign pad_out[i] = ctl[i].out;
    assign pad_pu[i]  = ctl[i].pu;
  end

  mux_gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (rd_data)
  );

endmodule

// File: rtl/mux_gpio_port_chk.sv
module mux_gpio_port_chk #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned OD_PINS     = 4,
  parameter int unsigned SHARED_PINS = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PP_PINS    = NUM_PINS - OD_PINS
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_PINS-1:0]    rd_data,
  input logic                   ser_bus_en,
  input logic                   uart_rx_en,
  input logic [SHARED_PINS-1:0] alt_low,
  input logic [PP_PINS-1:0]     pwm_en,
  input logic [PP_PINS-1:0]     pwm_val,
  input logic [PP_PINS-1:0]     func_en,
  input logic [PP_PINS-1:0]     func_val,
  input logic [NUM_PINS-1:0]    pad_in,
  input logic [NUM_PINS-1:0]    pad_out,
  input logic [NUM_PINS-1:0]    pad_oe,
  input logic [NUM_PINS-1:0]    pad_pu
);

  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst)              age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  for (genvar i = 0; i < OD_PINS; i++) begin : g_od
    assert_od_never_high_R3: assert property (@(posedge clk) disable iff (rst)
      pad_oe[i] |-> !pad_out[i]);
    assert_od_no_pullup_R4: assert property (@(posedge clk) disable iff (rst)
      !pad_pu[i]);
  end

  for (genvar k = 0; k < PP_PINS; k++) begin : g_pp
    assert_pp_pull_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
      pad_pu[OD_PINS+k] |-> !pad_oe[OD_PINS+k]);
    assert_pp_alt_drive_R8: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && $past(pwm_en[k] | func_en[k])) |->
        (pad_oe[OD_PINS+k] && !pad_pu[OD_PINS+k] &&
         pad_out[OD_PINS+k] == ($past(pwm_en[k]) ? $past(pwm_val[k]) : $past(func_val[k]))));
  end

  assert_shared_alt_R5: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $past(ser_bus_en | uart_rx_en)) |->
      (pad_oe[SHARED_PINS-1:0] == $past(alt_low)));

  if (SYNC_STAGES == 2) begin : g_sync2
    assert_read_delay_R10: assert property (@(posedge clk) disable iff (rst)
      (age >= 2'd2) |-> (rd_data == $past(pad_in, 2)));
  end

endmodule

bind mux_gpio_port mux_gpio_port_chk #(
  .NUM_PINS(NUM_PINS), .OD_PINS(OD_PINS), .SHARED_PINS(SHARED_PINS), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst(rst), .rd_data(rd_data), .ser_bus_en(ser_bus_en), .uart_rx_en(uart_rx_en),
  .alt_low(alt_low), .pwm_en(pwm_en), .pwm_val(pwm_val), .func_en(func_en), .func_val(func_val),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/mux_gpio_port_tb.sv
module mux_gpio_port_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string    tag;
    logic [7:0] oe;
    logic [7:0] out;
    logic [7:0] pu;
    logic [7:0] rd;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] wdata = '0;
  logic       wr_oe = 1'b0, wr_out = 1'b0;
  logic [7:0] rd_data;
  logic       ser_bus_en = 1'b0, uart_rx_en = 1'b0;
  logic [1:0] alt_low = '0;
  logic [3:0] pwm_en = '0, pwm_val = '0, func_en = '0, func_val = '0;
  logic [7:0] pad_in = 8'hA5;
  logic [7:0] pad_out, pad_oe, pad_pu;

  logic [7:0] sh_oe = '0, sh_out = '0;
  exp_t       q [$];
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_gpio_port u_dut (
    .clk(clk), .rst(rst), .wdata(wdata), .wr_oe(wr_oe), .wr_out(wr_out), .rd_data(rd_data),
    .ser_bus_en(ser_bus_en), .uart_rx_en(uart_rx_en), .alt_low(alt_low),
    .pwm_en(pwm_en), .pwm_val(pwm_val), .func_en(func_en), .func_val(func_val),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // Expected pad controls built from the requirements and the bench's register shadow
  task automatic model(output logic [7:0] e_oe, output logic [7:0] e_out, output logic [7:0] e_pu);
    for (int i = 0; i < 4; i++) begin
      e_pu[i] = 1'b0; e_out[i] = 1'b0;
      if (i < 2 && (ser_bus_en || uart_rx_en)) e_oe[i] = alt_low[i];
      else e_oe[i] = sh_oe[i] & ~sh_out[i];
    end
    for (int k = 0; k < 4; k++) begin
      if (pwm_en[k] || func_en[k]) begin
        e_oe[4+k] = 1'b1; e_pu[4+k] = 1'b0;
        e_out[4+k] = pwm_en[k] ? pwm_val[k] : func_val[k];
      end else begin
        e_oe[4+k] = sh_oe[4+k]; e_out[4+k] = sh_out[4+k]; e_pu[4+k] = ~sh_oe[4+k];
      end
    end
  endtask

  task automatic push_rd(input string tag, input logic [7:0] rd);
    exp_t e;
    e.tag = tag; e.rd = rd;
    model(e.oe, e.out, e.pu);
    q.push_back(e);
  endtask

  task automatic push(input string tag);
    push_rd(tag, pad_in);
  endtask

  task automatic settle(input string tag);
    repeat (3) @(posedge clk);
    #1 push(tag);
  endtask

  task automatic write_reg(input bit to_oe, input logic [7:0] v, input bit lat);
    @(negedge clk);
    wdata = v;
    if (to_oe) wr_oe = 1'b1; else wr_out = 1'b1;
    @(posedge clk);
    #1 if (lat) push("R11 pad unchanged one edge after write");
    if (to_oe) sh_oe = v; else sh_out = v;
    @(negedge clk);
    wr_oe = 1'b0; wr_out = 1'b0;
    @(posedge clk);
    #1 if (lat) push("R2 register applied after two edges");
  endtask

  // Monitor: compares the oldest expected item at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (pad_oe !== e.oe || pad_out !== e.out || pad_pu !== e.pu || rd_data !== e.rd) begin
        n_bad++;
        $display("FAIL %s: actual oe=%h out=%h pu=%h rd=%h expected oe=%h out=%h pu=%h rd=%h",
                 e.tag, pad_oe, pad_out, pad_pu, rd_data, e.oe, e.out, e.pu, e.rd);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    settle("R1 reset state");

    // R2/R11: enable register, then data register with latency checks
    write_reg(1'b1, 8'hFF, 1'b1);
    write_reg(1'b0, 8'h00, 1'b1);
    settle("R3 open-drain pins pull low, R6 push-pull drives 0");
    write_reg(1'b0, 8'h5A, 1'b0);
    settle("R3 open-drain releases on 1, R6 push-pull follows data");
    write_reg(1'b1, 8'h0F, 1'b0);
    settle("R7 push-pull input with pull-up, R2 data kept");
    write_reg(1'b1, 8'hF0, 1'b0);
    settle("R4 open-drain input without pull-up");
    write_reg(1'b1, 8'h3C, 1'b0);
    write_reg(1'b0, 8'hC3, 1'b0);
    settle("R3 R6 R7 mixed pattern");

    // R5: serial bus then UART take pins 0 and 1
    write_reg(1'b1, 8'hFF, 1'b0);
    write_reg(1'b0, 8'h00, 1'b0);
    @(negedge clk); ser_bus_en = 1'b1; alt_low = 2'b01;
    @(posedge clk); #1 push("R11 R5 serial bus owns pins 0-1 after one edge");
    @(negedge clk); ser_bus_en = 1'b0; uart_rx_en = 1'b1; alt_low = 2'b10;
    settle("R5 UART owns pins 0-1");
    // R9: write while owned, no effect on pins 0-1
    write_reg(1'b0, 8'h01, 1'b0);
    settle("R9 write during ownership leaves pins 0-1");
    @(negedge clk); uart_rx_en = 1'b0;
    settle("R9 released pins follow current registers");

    // R8: PWM and special function on pins 4-7
    write_reg(1'b1, 8'hF0, 1'b0);
    write_reg(1'b0, 8'hF0, 1'b0);
    @(negedge clk); pwm_en = 4'b0011; pwm_val = 4'b0101; func_en = 4'b0110; func_val = 4'b1010;
    @(posedge clk); #1 push("R11 R8 PWM wins over special function");
    write_reg(1'b0, 8'h00, 1'b0);
    write_reg(1'b1, 8'h00, 1'b0);
    settle("R9 R8 owned pins ignore writes, pin 7 input");
    @(negedge clk); pwm_en = 4'b0000; func_en = 4'b1000; func_val = 4'b0000;
    settle("R8 special function drives 0 on pin 7, R7 others input");
    @(negedge clk); func_en = 4'b0000;
    settle("R9 pins 4-7 back to GPIO");

    // R10: read path delay
    for (int j = 0; j < 4; j++) begin
      logic [7:0] old_v, new_v;
      new_v = 8'h3C ^ (8'h11 << j);
      @(negedge clk); old_v = pad_in; pad_in = new_v;
      @(posedge clk); #1 push_rd("R10 read still old after one edge", old_v);
      @(posedge clk); #1 push_rd("R10 read new after two edges", new_v);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule